// File: doc/BRIEF.md
# Parallel Port Channel with Read Strobe Handshake

This block is one 8-bit peripheral port channel of a parallel interface adapter. It holds an output register, a per-bit direction register and a control register. It watches an edge-sensitive control input C1 and drives or watches a second control line C2. The host reaches the channel through a one-bit register select, single-cycle read and write strobes, a write data byte and a read data byte. The peripheral side sees the output byte with per-bit drive enables, the input pins, C1, and C2 in both directions. The channel raises one active-high interrupt request.

When C2 is set up as a strobe output, a host read of the port data pulls C2 low. This tells the peripheral that the byte has been taken. C2 goes high again on one of two conditions, chosen by a control bit. The first is the next active C1 edge, for a full handshake. The second is the next clock, which gives a one-cycle pulse. A read of the port data also clears both interrupt flags.

The control register uses these fields:

| Bit(s) | Meaning |
|---|---|
| 0 | Enables the C1 interrupt |
| 1 | C1 active edge: 1 = rising, 0 = falling |
| 2 | Selects output register (1) or direction register (0) at address 0 |
| 5:3 | C2 mode |
| 7:6 | Read-only flags |

Top module: `pia_port_ch`

## Requirements
- R1: While reset is asserted, and until the first write after it, all three registers read 0 and every pin_oe bit is 0. Both flags are 0, irq is 0, c2_out is 1, and the previous-level samples of C1 and C2 are taken as 0.
- R2: A write with rs=0 goes to the output register when control bit 2 is 1, and to the direction register when bit 2 is 0. pin_out shows the output register and pin_oe shows the direction register, from the cycle after the write.
- R3: rdata is 0 when rd is low. When rd is high with rs=0 and control bit 2 = 1, rdata equals (output & direction) | (pin_in & ~direction) in that same cycle. When rd is high with rs=0 and bit 2 = 0, rdata equals the direction register.
- R4: A C1 edge is a change of c1_in from its level at the previous clock. The edge is active only when it matches control bit 1 (1 = rising, 0 = falling). An active edge sets flag 1 at that clock. An inactive edge changes nothing.
- R5: A write with rs=1 loads control bits 5:0 from wdata[5:0]. A read with rs=1 returns {flag1, flag2 & ~bit5, bits 5:0}, which puts flag 1 in bit 7 and flag 2 in bit 6. This read clears neither flag.
- R6: A port data read (rd, rs=0, bit 2 = 1) clears both flags at that clock. If an active edge arrives in the same cycle, the flag it sets stays set. A read of the direction register clears nothing.
- R7: In C2 mode 100 (strobe, C1 restore), a port data read drives c2_out low from the next cycle. c2_out stays low until the cycle after an active C1 edge. If a read and an active C1 edge fall in the same cycle, the read wins.
- R8: In C2 mode 101 (strobe, clock restore), a port data read drives c2_out low for exactly one cycle, after which it returns high.
- R9: In C2 modes 11x, c2_out equals control bit 3 from the cycle after the control write. c2_oe equals control bit 5.
- R10: With control bit 5 = 0, C2 is an input. A c2_in change that matches bit 4 (1 = rising) sets flag 2.
- R11: irq = (flag1 & bit0) | (flag2 & bit3 & ~bit5). irq changes in the same cycle as the flags and control bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rs | input | 1 | Register select: 0 port/direction, 1 control |
| rd | input | 1 | Single-cycle read strobe |
| wr | input | 1 | Single-cycle write strobe |
| wdata | input | 8 | Write data from host |
| rdata | output | 8 | Read data to host, combinational |
| pin_in | input | 8 | Peripheral input pins |
| pin_out | output | 8 | Output register value |
| pin_oe | output | 8 | Per-bit drive enable (direction register) |
| c1_in | input | 1 | Edge-sensitive control input |
| c2_in | input | 1 | C2 level when used as input |
| c2_out | output | 1 | C2 driven level |
| c2_oe | output | 1 | C2 drive enable |
| irq | output | 1 | Active-high interrupt request |

## Verification
- **Same cycle:** read data is combinational, so it is due in the cycle the read strobe is high. The bench samples it within that cycle, once the inputs have settled.
- **One edge later:** register contents, flags, pin drive and C2 levels all change at the clock edge that takes the stimulus. They are therefore due one cycle later. irq follows the flags with no extra register, so it is due at that same point.
- **Clock-restore pulse:** the low level is due one cycle after the read, and the return to high is due one cycle after that.

**How the bench checks:** a behavioural model advances on each rising edge from the same inputs. The bench compares every output with the model at the following falling edge. Inputs change one time unit after that falling edge, so every sample falls between a settled input and the next edge. Directed checks with literal values are taken at those same points.

// File: rtl/pia_port_ch.sv
module pia_port_ch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rs,
  input  logic         rd,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe,
  input  logic         c1_in,
  input  logic         c2_in,
  output logic         c2_out,
  output logic         c2_oe,
  output logic         irq
);

  logic [W-1:0] out_r, ddr_r;
  logic [5:0]   ctl;
  logic         f1, f2, c1_q, c2_q, c2_r, e_pend;

  wire sel_data  = ctl[2];
  wire rd_data   = rd && !rs && sel_data;
  wire c2_input  = !ctl[5];
  wire strobe    = ctl[5:4] == 2'b10;
  wire manual    = ctl[5:4] == 2'b11;
  wire c1_act    = (c1_in != c1_q) && (c1_in == ctl[1]);
  wire c2_act    = c2_input && (c2_in != c2_q) && (c2_in == ctl[4]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_r <= '0;
      ddr_r <= '0;
      ctl   <= '0;
    end else if (wr) begin
      if (rs)            ctl   <= wdata[5:0];
      else if (sel_data) out_r <= wdata;
      else               ddr_r <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c1_q <= 1'b0;
      c2_q <= 1'b0;
      f1   <= 1'b0;
      f2   <= 1'b0;
    end else begin
      c1_q <= c1_in;
      c2_q <= c2_in;
      if (c1_act)       f1 <= 1'b1;
      else if (rd_data) f1 <= 1'b0;
      if (c2_act)       f2 <= 1'b1;
      else if (rd_data) f2 <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c2_r   <= 1'b1;
      e_pend <= 1'b0;
    end else begin
      e_pend <= rd_data && strobe && ctl[3];
      if (rd_data && strobe)                   c2_r <= 1'b0;
      else if (e_pend)                         c2_r <= 1'b1;
      else if (strobe && !ctl[3] && c1_act)    c2_r <= 1'b1;
    end
  end

  always_comb begin
    rdata = '0;
    if (rd) begin
      if (rs)            rdata = {f1, f2 & c2_input, ctl};
      else if (sel_data) rdata = (out_r & ddr_r) | (pin_in & ~ddr_r);
      else               rdata = ddr_r;
    end
  end

  assign pin_out = out_r;
  assign pin_oe  = ddr_r;
  assign c2_oe   = ctl[5];
  assign c2_out  = manual ? ctl[3] : c2_r;
  assign irq     = (f1 && ctl[0]) || (f2 && ctl[3] && c2_input);

  a_r4_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    (!f1 && !c1_act) |=> !f1);

  a_r5_ctl_read_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && rs && !c1_act && !c2_act) |=> ($stable(f1) && $stable(f2)));

  a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && !c1_act && !c2_act) |=> (!f1 && !f2));

  a_r7_c1_restore: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl[5:3] == 3'b100 && c1_act && !rd_data && !wr) |=> c2_out);

  a_r8_pulse_low: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && ctl[5:3] == 3'b101 && !wr) |=> !c2_out);

  a_r8_pulse_high: assert property (@(posedge clk) disable iff (!rst_n)
    (e_pend && !rd_data && !wr && ctl[5:4] == 2'b10) |=> c2_out);

endmodule

// File: tb/tb_pia_port_ch.sv
module tb_pia_port_ch;
  logic clk = 1'b0, rst_n = 1'b0;
  logic rs = 0, rd = 0, wr = 0, c1_in = 0, c2_in = 0;
  logic [7:0] wdata = 0, pin_in = 0;
  logic [7:0] rdata, pin_out, pin_oe;
  logic c2_out, c2_oe, irq;
  int nchk = 0, nfail = 0, cyc = 0;

  pia_port_ch dut (.clk(clk), .rst_n(rst_n), .rs(rs), .rd(rd), .wr(wr),
    .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .c1_in(c1_in), .c2_in(c2_in), .c2_out(c2_out),
    .c2_oe(c2_oe), .irq(irq));

  always #10 clk = ~clk;

  // behavioural model
  int m_out = 0, m_ddr = 0, m_ctl = 0;
  bit m_f1 = 0, m_f2 = 0, m_c2 = 1, m_pulse = 0, m_c1p = 0, m_c2p = 0;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_out = 0; m_ddr = 0; m_ctl = 0; m_f1 = 0; m_f2 = 0;
      m_c2 = 1; m_pulse = 0; m_c1p = 0; m_c2p = 0;
    end else begin
      bit took, e1, e2, strobe_mode, clock_restore, n_pulse;
      int old_ctl;
      old_ctl = m_ctl;
      took = rd && !rs && old_ctl[2];
      e1 = (c1_in != m_c1p) && (c1_in == old_ctl[1]);
      e2 = (old_ctl[5] == 0) && (c2_in != m_c2p) && (c2_in == old_ctl[4]);
      strobe_mode = old_ctl[5:4] == 2'b10;
      clock_restore = old_ctl[3];
      n_pulse = took && strobe_mode && clock_restore;
      if (took && strobe_mode) m_c2 = 0;
      else if (m_pulse) m_c2 = 1;
      else if (strobe_mode && !clock_restore && e1) m_c2 = 1;
      m_pulse = n_pulse;
      if (e1) m_f1 = 1; else if (took) m_f1 = 0;
      if (e2) m_f2 = 1; else if (took) m_f2 = 0;
      if (wr) begin
        if (rs) m_ctl = wdata & 8'h3f;
        else if (old_ctl[2]) m_out = wdata;
        else m_ddr = wdata;
      end
      m_c1p = c1_in; m_c2p = c2_in;
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  function automatic int exp_rdata();
    if (!rd) return 0;
    if (rs) return {m_f1, m_f2 & ~m_ctl[5], m_ctl[5:0]};
    if (m_ctl[2]) return (m_out & m_ddr) | (pin_in & ~m_ddr);
    return m_ddr;
  endfunction

  always @(negedge clk) if (rst_n) begin
    int e_c2, e_irq;
    e_c2 = (m_ctl[5:4] == 2'b11) ? m_ctl[3] : m_c2;
    e_irq = (m_f1 & m_ctl[0]) | (m_f2 & m_ctl[3] & ~m_ctl[5]);
    chk(rdata == exp_rdata(), "R3 rdata", rdata, exp_rdata());
    chk(pin_out == m_out, "R2 pin_out", pin_out, m_out);
    chk(pin_oe == m_ddr, "R2 pin_oe", pin_oe, m_ddr);
    chk(c2_out == e_c2, "R7 c2_out", c2_out, e_c2);
    chk(c2_oe == m_ctl[5], "R9 c2_oe", c2_oe, m_ctl[5]);
    chk(irq == e_irq, "R11 irq", irq, e_irq);
  end

  task automatic tick(); @(negedge clk); #1; endtask

  task automatic bus_wr(bit s, logic [7:0] d);
    rs = s; wdata = d; wr = 1; tick(); wr = 0;
  endtask

  task automatic bus_rd(bit s, logic [7:0] exp, string req);
    rs = s; rd = 1; #1;
    chk(rdata == exp, req, rdata, exp);
    tick(); rd = 0;
  endtask

  initial begin
    repeat (3) tick();
    chk(pin_oe == 0 && c2_out == 1 && irq == 0 && pin_out == 0, "R1 reset",
        {pin_oe, c2_out, irq}, 8'h00 << 2 | 2);
    rst_n = 1; tick();
    bus_rd(1, 8'h00, "R1 ctl after reset");
    // R2 / R3 direction and port
    bus_wr(0, 8'hF0);
    bus_rd(0, 8'hF0, "R3 ddr read");
    bus_wr(1, 8'h04);
    bus_wr(0, 8'hA5);
    pin_in = 8'h3C;
    bus_rd(0, 8'hAC, "R3 mixed port read");
    chk(pin_out == 8'hA5 && pin_oe == 8'hF0, "R2 pins", pin_out, 8'hA5);
    // R4 C1 edges
    bus_wr(1, 8'h07);
    c1_in = 1; tick();
    chk(irq == 1, "R4 rising edge sets flag", irq, 1);
    bus_rd(1, 8'h87, "R5 ctl read shows flag1");
    chk(irq == 1, "R5 ctl read keeps flag", irq, 1);
    bus_rd(0, 8'hAC, "R6 port read");
    chk(irq == 0, "R6 read clears flag", irq, 0);
    c1_in = 0; tick();
    chk(irq == 0, "R4 inactive falling edge", irq, 0);
    // R7 strobe with C1 restore
    bus_wr(1, 8'h27);
    bus_rd(0, 8'hAC, "R7 strobe read");
    chk(c2_out == 0, "R7 strobe low", c2_out, 0);
    tick();
    chk(c2_out == 0, "R7 held low", c2_out, 0);
    c1_in = 1; tick();
    chk(c2_out == 1, "R7 restored by C1", c2_out, 1);
    c1_in = 0;
    // R8 clock restore
    bus_wr(1, 8'h2F);
    bus_rd(0, 8'hAC, "R8 strobe read");
    chk(c2_out == 0, "R8 one cycle low", c2_out, 0);
    tick();
    chk(c2_out == 1, "R8 back high", c2_out, 1);
    // R9 manual
    bus_wr(1, 8'h34);
    chk(c2_out == 0 && c2_oe == 1, "R9 manual low", c2_out, 0);
    bus_wr(1, 8'h3C);
    chk(c2_out == 1, "R9 manual high", c2_out, 1);
    // R10 C2 input edge
    bus_wr(1, 8'h1C);
    c2_in = 1; tick();
    chk(irq == 1, "R10 C2 edge sets flag2", irq, 1);
    bus_rd(1, 8'h5C, "R10 flag2 in bit 6");
    bus_wr(1, 8'h14);
    chk(irq == 0, "R11 irq masked", irq, 0);
    // randomized traffic
    for (int i = 0; i < 3000; i++) begin
      rd = ($urandom % 4) == 0;
      wr = ($urandom % 6) == 0;
      rs = $urandom % 2;
      wdata = $urandom;
      if ($urandom % 3 == 0) pin_in = $urandom;
      if ($urandom % 3 == 0) c1_in = ~c1_in;
      if ($urandom % 3 == 0) c2_in = ~c2_in;
      tick();
    end
    rd = 0; wr = 0;
    tick();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    #2000000;
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule